// File: doc/BRIEF.md
# Discrete cartridge bank mapper

This block is the banking logic of a cartridge for an 8-bit console. It watches CPU writes to the upper half of the address space and keeps two kinds of state. The first is a program register, which holds a 16 kB bank number and a mirroring flag. The second is a file of four character registers, each holding a 2 kB bank number.

From this state the block drives three sets of outputs, all combinationally:

- the upper program-ROM address lines for CPU reads;
- the upper character-ROM address lines for video-chip fetches;
- the nametable RAM address bit that sets the mirroring arrangement.

The register decode is deliberately sparse. A character register's slot index is CPU address bits 13..12 plus one, modulo 4. The program decode ignores CPU address bit 13, so a write to `$B000-$BFFF` loads both the program register and character slot 0.

A small two-state machine qualifies the write strobe, which is sampled on `clk`. The states are `WS_IDLE` (waiting for a strobe) and `WS_HELD` (the strobe is still high after it was taken). `WS_IDLE` goes to `WS_HELD` when the strobe is high; that same cycle issues a single write pulse. `WS_HELD` stays in place while the strobe stays high. `WS_HELD` returns to `WS_IDLE` when the strobe drops. Reset forces `WS_IDLE`.

Top module: `disc_bank_mapper`

## Requirements
- R1: After reset, every register is zero. A CPU read at `$8000-$BFFF` gives program bank 0, all four character slots give bank 0, and mirroring is vertical.
- R2: A write in `$8000-$BFFF` (address bits 15..14 = 10) loads the program bank from data bits 4..1 and the mirroring flag from data bit 7.
- R3: `prg_hi` gives the stored bank when CPU address bit 14 is 0. It gives bank 15 (all ones) when CPU address bit 14 is 1, so `$C000-$FFFF` reads use the last bank.
- R4: `nt_page` equals video address bit 10 when the flag is 0 (vertical) and video address bit 11 when the flag is 1 (horizontal).
- R5: A write with CPU address bits 15..12 equal to 1011, 1100, 1101 or 1110 loads data bits 6..1 into character slot (bits 13..12 + 1) mod 4. That gives `$Bxxx`→0, `$Cxxx`→1, `$Dxxx`→2 and `$Exxx`→3. Address bits 11..0 are ignored.
- R6: `chr_hi` gives the bank number held in the slot chosen by video address bits 12..11.
- R7: A single write in `$B000-$BFFF` updates both the program register (bank and flag) and character slot 0.
- R8: Writes to `$F000-$FFFF` change no character slot. Writes below `$8000` change no register. Writes to `$C000-$FFFF` leave the program register unchanged.
- R9: A write strobe held high for several clock cycles performs exactly one write, using the address and data present in the first cycle it is seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that samples the write strobe |
| rst_n | input | 1 | Active-low reset, clears all registers |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | CPU write strobe, active high |
| ppu_addr | input | 14 | Video-chip address |
| prg_hi | output | 4 | Program-ROM address bits 17..14 |
| chr_hi | output | 6 | Character-ROM address bits 16..11 |
| nt_page | output | 1 | Nametable RAM address bit 10 |

## Verification
Each character slot is loaded with a distinct bank number, and the slots are then read back over all four video quarters. This separates a correct +1 slot rotation from an unrotated or reversed mapping. The data values use set bits at both ends of their fields, which exposes off-by-one data slicing. A write to `$B000` with a known pattern tells apart a shared decode from one that ignores either target. Writes to `$F000`, to `$7000` and to `$C000` show that the out-of-range paths stay quiet. Both mirroring modes are probed at addresses where bits 10 and 11 differ. A strobe held while the data changes shows whether the edge qualifier takes a second write.

// File: rtl/mapper_pkg.sv
`timescale 1ns/1ps
package mapper_pkg;

    localparam int PRG_W_DEF  = 4;
    localparam int CHR_W_DEF  = 6;
    localparam int SLOT_N_DEF = 4;

    typedef enum logic {
        WS_IDLE = 1'b0,
        WS_HELD = 1'b1
    } wr_state_e;

    // slot index is the register address field plus one, wrapping
    function automatic logic [1:0] slot_of(input logic [1:0] field);
        return field + 2'd1;
    endfunction

endpackage

// File: rtl/wr_edge_fsm.sv
`timescale 1ns/1ps
module wr_edge_fsm
    import mapper_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_in,
    output logic fire
);

    wr_state_e state_q;
    wr_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE: if (wr_in)  state_d = WS_HELD;
            WS_HELD: if (!wr_in) state_d = WS_IDLE;
            default: state_d = WS_IDLE;
        endcase
    end

    always_comb begin
        fire = 1'b0;
        unique case (state_q)
            WS_IDLE: fire = wr_in;
            WS_HELD: fire = 1'b0;
            default: fire = 1'b0;
        endcase
    end

    // R9: a strobe yields one pulse only
    p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);

endmodule

// File: rtl/prg_reg_unit.sv
`timescale 1ns/1ps
module prg_reg_unit #(
    parameter int PRG_W = mapper_pkg::PRG_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire,
    input  logic [1:0]       addr_top,
    input  logic [PRG_W-1:0] bank_in,
    input  logic             mirror_in,
    output logic [PRG_W-1:0] prg_hi,
    output logic             mirror_h
);

    logic [PRG_W-1:0] bank_q;
    logic             mirror_q;
    logic             wr_sel;

    // bit 13 deliberately not decoded
    assign wr_sel = (addr_top == 2'b10);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q   <= '0;
            mirror_q <= 1'b0;
        end else if (fire && wr_sel) begin
            bank_q   <= bank_in;
            mirror_q <= mirror_in;
        end
    end

    always_comb begin
        prg_hi   = addr_top[0] ? {PRG_W{1'b1}} : bank_q;
        mirror_h = mirror_q;
    end

    // R2: load takes the data field of the write cycle
    p_prg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && wr_sel) |=> (bank_q == $past(bank_in)) && (mirror_q == $past(mirror_in)));

    // R8: writes outside $8000-$BFFF leave the program register alone
    p_prg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !wr_sel) |=> $stable(bank_q) && $stable(mirror_q));

endmodule

// File: rtl/chr_reg_file.sv
`timescale 1ns/1ps
module chr_reg_file
    import mapper_pkg::*;
#(
    parameter int CHR_W  = CHR_W_DEF,
    parameter int SLOT_N = SLOT_N_DEF
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      fire,
    input  logic [3:0]                region,
    input  logic [CHR_W-1:0]          bank_in,
    input  logic [$clog2(SLOT_N)-1:0] vid_sel,
    output logic [CHR_W-1:0]          chr_hi
);

    localparam int SLOT_W = $clog2(SLOT_N);

    logic [SLOT_N-1:0][CHR_W-1:0] bank_q;
    logic [SLOT_N-1:0]            hit;
    logic                         is_chr;
    logic [SLOT_W-1:0]            slot;

    assign is_chr = (region == 4'hB) || (region == 4'hC)
                 || (region == 4'hD) || (region == 4'hE);
    assign slot   = slot_of(region[1:0]);

    for (genvar i = 0; i < SLOT_N; i++) begin : g_hit
        assign hit[i] = fire && is_chr && (slot == SLOT_W'(i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            for (int i = 0; i < SLOT_N; i++) begin
                if (hit[i]) bank_q[i] <= bank_in;
            end
        end
    end

    assign chr_hi = bank_q[vid_sel];

    // R5: at most one slot written per pulse
    p_one_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R8: top page never writes a character slot
    p_chr_top_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && region == 4'hF) |=> $stable(bank_q));

endmodule

// File: rtl/disc_bank_mapper.sv
`timescale 1ns/1ps
module disc_bank_mapper
    import mapper_pkg::*;
#(
    parameter int PRG_W = PRG_W_DEF,
    parameter int CHR_W = CHR_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      cpu_addr,
    input  logic [7:0]       cpu_data,
    input  logic             cpu_wr,
    input  logic [13:0]      ppu_addr,
    output logic [PRG_W-1:0] prg_hi,
    output logic [CHR_W-1:0] chr_hi,
    output logic             nt_page
);

    logic fire;
    logic mirror_h;
    logic unused_bits;

    assign unused_bits = ^{cpu_data[0], ppu_addr[13], cpu_addr[11:0]};

    wr_edge_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_in (cpu_wr),
        .fire  (fire)
    );

    prg_reg_unit #(.PRG_W(PRG_W)) u_prg (
        .clk       (clk),
        .rst_n     (rst_n),
        .fire      (fire),
        .addr_top  (cpu_addr[15:14]),
        .bank_in   (cpu_data[PRG_W:1]),
        .mirror_in (cpu_data[7]),
        .prg_hi    (prg_hi),
        .mirror_h  (mirror_h)
    );

    chr_reg_file #(.CHR_W(CHR_W), .SLOT_N(4)) u_chr (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (fire),
        .region  (cpu_addr[15:12]),
        .bank_in (cpu_data[CHR_W:1]),
        .vid_sel (ppu_addr[12:11]),
        .chr_hi  (chr_hi)
    );

    assign nt_page = mirror_h ? ppu_addr[11] : ppu_addr[10];

    // R3: reads of the upper quarter always see the last bank
    p_fixed_top_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:14] == 2'b11) |-> (prg_hi == {PRG_W{1'b1}}));

endmodule

// File: tb/tb_disc_bank_mapper.sv
`timescale 1ns/1ps
module tb_disc_bank_mapper;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_data = 8'h00;
    logic        cpu_wr = 1'b0;
    logic [13:0] ppu_addr = 14'h0000;
    logic [3:0]  prg_hi;
    logic [5:0]  chr_hi;
    logic        nt_page;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    disc_bank_mapper dut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
        .cpu_wr(cpu_wr), .ppu_addr(ppu_addr), .prg_hi(prg_hi),
        .chr_hi(chr_hi), .nt_page(nt_page)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_data = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic rd_prg(input logic [15:0] a, output int v);
        cpu_addr = a; #1; v = prg_hi;
    endtask

    task automatic rd_chr(input int slot, output int v);
        ppu_addr = 14'(slot * 14'h0800 + 14'h0123); #1; v = chr_hi;
    endtask

    task automatic rd_nt(input logic [13:0] a, output int v);
        ppu_addr = a; #1; v = nt_page;
    endtask

    task automatic t_reset();
        int v;
        rd_prg(16'h8000, v); check("R1 prg", v, 0);
        for (int s = 0; s < 4; s++) begin
            rd_chr(s, v); check("R1 chr", v, 0);
        end
        rd_nt(14'h2400, v); check("R1 vertical", v, 1);
        rd_nt(14'h2800, v); check("R1 vertical", v, 0);
    endtask

    task automatic t_prg();
        int v;
        cpu_write(16'h8000, 8'h12);          // bank 9, flag 0
        rd_prg(16'h8000, v); check("R2 bank", v, 9);
        cpu_write(16'hA555, 8'h1E);          // bank 15
        rd_prg(16'h9FFF, v); check("R2 bank", v, 15);
        cpu_write(16'h8000, 8'h02);          // bank 1
        rd_prg(16'hBFFF, v); check("R2 bank", v, 1);
        rd_prg(16'hC000, v); check("R3 fixed", v, 15);
        rd_prg(16'hFFFF, v); check("R3 fixed", v, 15);
    endtask

    task automatic t_mirror();
        int v;
        cpu_write(16'h8000, 8'h86);          // flag 1, bank 3
        rd_prg(16'h8000, v); check("R2 bank with flag", v, 3);
        rd_nt(14'h2800, v); check("R4 horizontal", v, 1);
        rd_nt(14'h2400, v); check("R4 horizontal", v, 0);
        cpu_write(16'h8000, 8'h06);          // flag 0
        rd_nt(14'h2400, v); check("R4 vertical", v, 1);
        rd_nt(14'h2C00, v); check("R4 vertical", v, 1);
        rd_nt(14'h2800, v); check("R4 vertical", v, 0);
    endtask

    task automatic t_chr();
        int v;
        cpu_write(16'hB000, 8'h02);          // slot 0 = 1
        cpu_write(16'hC123, 8'h0A);          // slot 1 = 5
        cpu_write(16'hDFFF, 8'h14);          // slot 2 = 10
        cpu_write(16'hE000, 8'h7E);          // slot 3 = 63
        rd_chr(0, v); check("R5 R6 slot0", v, 1);
        rd_chr(1, v); check("R5 R6 slot1", v, 5);
        rd_chr(2, v); check("R5 R6 slot2", v, 10);
        rd_chr(3, v); check("R5 R6 slot3", v, 63);
    endtask

    task automatic t_shared();
        int v;
        cpu_write(16'hB000, 8'h5A);          // prg 13, flag 0, chr 45
        rd_prg(16'h8000, v); check("R7 prg", v, 13);
        rd_chr(0, v); check("R7 chr slot0", v, 45);
        rd_nt(14'h2400, v); check("R7 flag", v, 1);
        cpu_write(16'hB800, 8'hC0);          // prg 0, flag 1, chr 32
        rd_prg(16'h8000, v); check("R7 prg", v, 0);
        rd_chr(0, v); check("R7 chr slot0", v, 32);
        rd_nt(14'h2800, v); check("R7 flag", v, 1);
    endtask

    task automatic t_ignored();
        int v;
        cpu_write(16'h8000, 8'h0C);          // prg 6, flag 0
        cpu_write(16'hF000, 8'h7E);
        rd_chr(0, v); check("R8 F000 slot0", v, 32);
        rd_chr(1, v); check("R8 F000 slot1", v, 5);
        rd_chr(2, v); check("R8 F000 slot2", v, 10);
        rd_chr(3, v); check("R8 F000 slot3", v, 63);
        rd_prg(16'h8000, v); check("R8 F000 prg", v, 6);
        cpu_write(16'h7000, 8'h9E);
        rd_prg(16'h8000, v); check("R8 low prg", v, 6);
        rd_nt(14'h2800, v); check("R8 low flag", v, 0);
        rd_chr(3, v); check("R8 low chr", v, 63);
        cpu_write(16'hC000, 8'h9E);          // slot 1 = 15, prg untouched
        rd_chr(1, v); check("R8 C000 chr", v, 15);
        rd_prg(16'h8000, v); check("R8 C000 prg", v, 6);
        rd_nt(14'h2800, v); check("R8 C000 flag", v, 0);
    endtask

    task automatic t_held();
        int v;
        @(negedge clk);
        cpu_addr = 16'h8000; cpu_data = 8'h06; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_data = 8'h0A;
        @(negedge clk);
        cpu_addr = 16'hE000; cpu_data = 8'h04;
        @(negedge clk);
        cpu_wr = 1'b0;
        @(negedge clk);
        rd_prg(16'h8000, v); check("R9 held strobe", v, 3);
        rd_chr(3, v); check("R9 held strobe chr", v, 63);
        cpu_write(16'h8000, 8'h0A);
        rd_prg(16'h8000, v); check("R9 next strobe", v, 5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prg();
        t_mirror();
        t_chr();
        t_shared();
        t_ignored();
        t_held();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule